// File: doc/BRIEF.md
# Three-Level Cell Read Sequencer

This block turns the outputs of resistive-cell sense comparators into a 2-bit trit code. The cell holds one of three resistance levels: a high-resistance level, which reads as the smallest value, and two distinct low-resistance levels. A host pulses a start input. The block raises busy and drives a sense-enable strobe for a programmable number of settle cycles. It then samples the comparators and returns the trit together with a one-cycle done pulse.

A static mode input picks one of two decode schemes. In parallel mode two comparators run at once. One compares the cell against a low reference, which sits between the high-resistance level and the first low-resistance level. The other compares against a high reference, which sits between the two low-resistance levels. One settle window is enough to decode. In serial mode only the low-reference comparator input is used. A reference-select output steers that comparator: it first compares against the low reference and, only if the cell current is above it, runs a second settle window against the high reference. The serial path therefore takes one or two windows depending on the stored level.

A comparator output of 1 means the cell current is above the reference being used. Mode and settle count are captured when start is accepted.

Top module: `trit_read_seq`

## Requirements
- R1: While reset is high and after it is released, busy, done, sense-enable, reference-select, the trit (code 00) and the illegal flag are all 0.
- R2: In parallel mode, with the {low-ref, high-ref} comparator pair sampled at the end of the settle window, 00 returns trit 00, 10 returns trit 01 and 11 returns trit 10. Reference-select stays 0 throughout, and the trit output never shows code 11.
- R3: In parallel mode the pair 01 returns trit 00 with the illegal flag set to 1. Any legal result returns the flag as 0.
- R4: With an effective settle count N, a parallel read raises done N cycles after the clock edge that accepted start. Sense-enable is high for exactly those N cycles and equals busy at all times.
- R5: In serial mode the first step compares against the low reference (reference-select 0). If the low-reference comparator reads 0, the read ends with trit 00 after N cycles.
- R6: In serial mode, when the first comparison reads 1, reference-select goes to 1 for a second window of N cycles, and the result is trit 10 if the comparator then reads 1 and trit 01 if it reads 0. Done comes 2N cycles after start. The high-reference comparator input is ignored and the illegal flag stays 0.
- R7: Done is a single-cycle pulse, never high together with busy, and busy falls in the cycle done rises.
- R8: A start seen while busy is ignored. Changes to mode or settle count during a read do not alter its latency or result, and no extra read follows.
- R9: A settle count of 0 is treated as 1.
- R10: The trit and illegal flag hold their values between completions, whatever the comparators do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a read (taken only when idle) |
| mode_i | input | 1 | 0 = parallel decode, 1 = serial binary search |
| settle_cyc_i | input | SETTLE_W | Settle cycles per sense step (0 acts as 1) |
| cmp_lo_i | input | 1 | Comparator versus the low reference (or the selected reference in serial mode) |
| cmp_hi_i | input | 1 | Comparator versus the high reference (parallel mode only) |
| busy_o | output | 1 | Read in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sense_en_o | output | 1 | Sense strobe, high during settle windows |
| ref_sel_o | output | 1 | Reference select: 0 low reference, 1 high reference |
| trit_o | output | 2 | Result code 00, 01 or 10 |
| illegal_o | output | 1 | Parallel comparator pair was inconsistent |

## Verification
The bench models the cell so that both comparators follow the stored level and the reference-select output. It counts cycles from the accepting edge to done, and it counts how long sense-enable and reference-select stay high. This catches three kinds of fault: a serial read that skips its early exit and spends 2N cycles on level zero, an off-by-one settle counter, and a second step that reuses the low reference and returns the wrong trit. The inconsistent pattern 01 is forced in both modes. A design that decodes it as a valid level fails in parallel mode, and one that reads the high-reference input in serial mode flags it wrongly. Start pulses and mode and settle changes arrive mid-read, which exposes designs that restart or do not latch their setup. A settle count of zero exposes a design that hangs or underflows its counter.

// File: rtl/trit_rd_pkg.sv
package trit_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_STEP1, ST_STEP2} seq_state_e;

  localparam logic [1:0] TRIT_ZERO = 2'b00;
  localparam logic [1:0] TRIT_ONE  = 2'b01;
  localparam logic [1:0] TRIT_TWO  = 2'b10;

  typedef struct packed {
    logic [1:0] trit;
    logic       bad;
  } decode_t;
endpackage

// File: rtl/trit_settle_timer.sv
module trit_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             active,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (active)    cnt_q <= cnt_q + CNT_W'(1);
  end

  // limit is never zero: the sequencer clamps it when it captures it
  assign expire = active && (cnt_q == limit - CNT_W'(1));

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt_q < limit)); // R4
endmodule

// File: rtl/trit_decode.sv
module trit_decode
  import trit_rd_pkg::*;
(
  input  logic    serial,
  input  logic    second_step,
  input  logic    cmp_lo,
  input  logic    cmp_hi,
  output decode_t dec
);
  always_comb begin
    dec = '{trit: TRIT_ZERO, bad: 1'b0};
    if (serial) begin
      // first step finishes only on a low result; second step picks 1 or 2
      if (second_step) dec.trit = cmp_lo ? TRIT_TWO : TRIT_ONE;
    end else begin
      unique case ({cmp_lo, cmp_hi})
        2'b00:   dec.trit = TRIT_ZERO;
        2'b10:   dec.trit = TRIT_ONE;
        2'b11:   dec.trit = TRIT_TWO;
        default: dec.bad  = 1'b1;
      endcase
    end
  end

  always_comb begin
    AST_SERIAL_NEVER_BAD: assert (!(serial && dec.bad)); // R6
  end
endmodule

// File: rtl/trit_read_seq.sv
module trit_read_seq
  import trit_rd_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                mode_i,
  input  logic [SETTLE_W-1:0] settle_cyc_i,
  input  logic                cmp_lo_i,
  input  logic                cmp_hi_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                sense_en_o,
  output logic                ref_sel_o,
  output logic [1:0]          trit_o,
  output logic                illegal_o
);
  localparam logic [SETTLE_W-1:0] MIN_SETTLE = SETTLE_W'(1);

  seq_state_e          state_q;
  logic                mode_q;
  logic [SETTLE_W-1:0] lim_q;
  logic                expire;
  logic                accept;
  logic                go_step2;
  logic                finish;
  decode_t             dec;

  assign accept   = start_i && (state_q == ST_IDLE);
  assign go_step2 = expire && (state_q == ST_STEP1) && mode_q && cmp_lo_i;
  assign finish   = expire && !go_step2;

  trit_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (accept || expire),
    .active  (state_q != ST_IDLE),
    .limit   (lim_q),
    .expire  (expire)
  );

  trit_decode u_dec (
    .serial      (mode_q),
    .second_step (state_q == ST_STEP2),
    .cmp_lo      (cmp_lo_i),
    .cmp_hi      (cmp_hi_i),
    .dec         (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mode_q     <= 1'b0;
      lim_q      <= MIN_SETTLE;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      sense_en_o <= 1'b0;
      ref_sel_o  <= 1'b0;
      trit_o     <= TRIT_ZERO;
      illegal_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        state_q    <= ST_STEP1;
        mode_q     <= mode_i;
        lim_q      <= (settle_cyc_i == '0) ? MIN_SETTLE : settle_cyc_i;
        busy_o     <= 1'b1;
        sense_en_o <= 1'b1;
        ref_sel_o  <= 1'b0;
      end else if (go_step2) begin
        state_q   <= ST_STEP2;
        ref_sel_o <= 1'b1;
      end else if (finish) begin
        state_q    <= ST_IDLE;
        busy_o     <= 1'b0;
        sense_en_o <= 1'b0;
        ref_sel_o  <= 1'b0;
        done_o     <= 1'b1;
        trit_o     <= dec.trit;
        illegal_o  <= dec.bad;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R7
  AST_SENSE_TRACKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    sense_en_o == busy_o); // R4
  AST_PAR_REF_FIXED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !mode_q) |-> !ref_sel_o); // R2
  AST_TRIT_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    trit_o != 2'b11); // R2
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (trit_o == TRIT_ZERO)); // R3
  AST_SERIAL_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (done_o && mode_q) |-> !illegal_o); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(trit_o) && $stable(illegal_o))); // R10
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i)); // R8
endmodule

// File: tb/tb_trit_read_seq.sv
module tb_trit_read_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       mode = 1'b0;
  logic [7:0] settle = 8'd1;
  int         level = 0;
  logic       use_ovr = 1'b0;
  logic       ovr_lo = 1'b0;
  logic       ovr_hi = 1'b0;
  logic       cmp_lo, cmp_hi;
  logic       busy, done, sense_en, ref_sel, illegal;
  logic [1:0] trit;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         ended = 1'b0;

  always #10ns clk = ~clk;

  // cell model: comparator follows stored level and the selected reference
  assign cmp_lo = use_ovr ? ovr_lo : (ref_sel ? (level >= 2) : (level >= 1));
  assign cmp_hi = use_ovr ? ovr_hi : (level >= 2);

  trit_read_seq #(.SETTLE_W(8)) dut (
    .clk(clk), .rst(rst), .start_i(start), .mode_i(mode),
    .settle_cyc_i(settle), .cmp_lo_i(cmp_lo), .cmp_hi_i(cmp_hi),
    .busy_o(busy), .done_o(done), .sense_en_o(sense_en),
    .ref_sel_o(ref_sel), .trit_o(trit), .illegal_o(illegal)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // one read: start, follow it to done, check latency, windows and result
  task automatic run_read(input logic md, input int lv, input bit force_bad,
                          input int st, input int exp_cyc, input logic [1:0] exp_t,
                          input logic exp_ill, input int exp_ref, input bit poke,
                          input string tag);
    int cyc = 0;
    int sen = 0;
    int rs  = 0;
    int dn  = 0;
    logic [1:0] held_t;
    logic       held_i;
    @(negedge clk);
    mode = md; level = lv; use_ovr = force_bad; ovr_lo = 1'b0; ovr_hi = 1'b1;
    settle = 8'(st); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (cyc < 2000) begin
      if (sense_en) sen++;
      if (ref_sel)  rs++;
      if (done) break;
      if (poke && cyc == 0) begin
        start = 1'b1; mode = ~md; settle = 8'd1;
      end
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start = 1'b0;
    end
    chk(cyc == exp_cyc, {tag, " latency"}, cyc, exp_cyc);
    chk(sen == exp_cyc, {tag, " sense window (R4)"}, sen, exp_cyc);
    chk(rs == exp_ref, {tag, " ref select cycles"}, rs, exp_ref);
    chk(trit == exp_t, {tag, " trit"}, trit, exp_t);
    chk(illegal == exp_ill, {tag, " illegal flag"}, illegal, exp_ill);
    chk(!busy, {tag, " busy at done (R7)"}, busy, 0);
    // R10: result holds while the cell changes; R7/R8: no stray completion
    held_t = trit; held_i = illegal;
    level = (lv + 1) % 3; use_ovr = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (done || busy) dn++;
    end
    chk(dn == 0, {tag, " no extra activity (R7 R8)"}, dn, 0);
    chk(trit == held_t && illegal == held_i, {tag, " result held (R10)"},
        {trit, illegal}, {held_t, held_i});
    mode = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({busy, done, sense_en, ref_sel, trit, illegal} == 7'd0, "R1 outputs in reset",
        {busy, done, sense_en, ref_sel, trit, illegal}, 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk({busy, done, sense_en, ref_sel, trit, illegal} == 7'd0, "R1 outputs after reset",
        {busy, done, sense_en, ref_sel, trit, illegal}, 0);
  endtask

  task automatic t_parallel();
    run_read(1'b0, 0, 1'b0, 3, 3, 2'b00, 1'b0, 0, 1'b0, "R2 R4 parallel level0");
    run_read(1'b0, 1, 1'b0, 3, 3, 2'b01, 1'b0, 0, 1'b0, "R2 R4 parallel level1");
    run_read(1'b0, 2, 1'b0, 5, 5, 2'b10, 1'b0, 0, 1'b0, "R2 R4 parallel level2");
  endtask

  task automatic t_illegal();
    run_read(1'b0, 0, 1'b1, 2, 2, 2'b00, 1'b1, 0, 1'b0, "R3 parallel pattern 01");
    run_read(1'b0, 1, 1'b0, 2, 2, 2'b01, 1'b0, 0, 1'b0, "R3 flag clears on legal");
  endtask

  task automatic t_serial();
    run_read(1'b1, 0, 1'b0, 4, 4, 2'b00, 1'b0, 0, 1'b0, "R5 serial early exit");
    run_read(1'b1, 1, 1'b0, 4, 8, 2'b01, 1'b0, 4, 1'b0, "R6 serial level1");
    run_read(1'b1, 2, 1'b0, 2, 4, 2'b10, 1'b0, 2, 1'b0, "R6 serial level2");
    run_read(1'b1, 0, 1'b1, 3, 3, 2'b00, 1'b0, 0, 1'b0, "R6 serial ignores high cmp");
  endtask

  task automatic t_zero_settle();
    run_read(1'b0, 2, 1'b0, 0, 1, 2'b10, 1'b0, 0, 1'b0, "R9 parallel settle 0");
    run_read(1'b1, 2, 1'b0, 0, 2, 2'b10, 1'b0, 1, 1'b0, "R9 serial settle 0");
  endtask

  task automatic t_busy_start();
    run_read(1'b1, 1, 1'b0, 5, 10, 2'b01, 1'b0, 5, 1'b1, "R8 start while busy serial");
    run_read(1'b0, 2, 1'b0, 4, 4, 2'b10, 1'b0, 0, 1'b1, "R8 start while busy parallel");
  endtask

  initial begin
    t_reset();
    t_parallel();
    t_illegal();
    t_serial();
    t_zero_settle();
    t_busy_start();
    finish_run();
  end

  initial begin
    #(20ns * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule